// File: doc/BRIEF.md
# Accumulator Data-Movement Execution Unit

This unit holds two byte accumulators, A and B. Together they form a double-width word register D, with A as the high half. It also holds two word-wide index registers, X and Y, and a byte-wide flag register. It executes one data-movement command per clock cycle: clear, load, store, register-to-register copy, flag-register copy and exchange. Each command class applies its own rule to the negative (N), zero (Z), overflow (V) and carry (C) flags.

A surrounding pipeline presents a 4-bit command code, a word-wide operand and a valid strobe. After the clock edge that accepts the command, the unit shows the updated registers on its outputs. For a store command, it also shows a one-cycle store strobe and the store data. All outputs are registered, and reset is synchronous and active high.

Flag-register bit layout: C is bit 0, V is bit 1, Z is bit 2 and N is bit 3. The upper bits carry no meaning inside the unit.

Top module: `dmu_core`

## Requirements
- R1: While `rst` is high at a clock edge, every register output and `st_data` become zero, and `st_valid` is low.
- R2: Code 0x0 clears A and code 0x1 clears B. Both clear N, V and C, set Z, and leave the other accumulator and bits 7:4 of the flag register unchanged.
- R3: Code 0x2 loads the low byte of the operand into A, and code 0x3 loads it into B. N is taken from bit 7 of that byte, Z is set when the byte is zero, and V is cleared.
- R4: Code 0x4 loads the operand into D: A takes operand bits 15:8 and B takes bits 7:0. N is taken from bit 15, Z is set when all 16 bits are zero, and V is cleared.
- R5: A store copies a register to `st_data` and pulses `st_valid` high for one cycle. Code 0x5 stores A, zero-extended; code 0x6 stores B, zero-extended; code 0x7 stores D. N and Z are taken from the stored value (sign bit at bit 7 for a byte, bit 15 for D), and V is cleared. The data registers do not change.
- R6: Code 0x8 copies A into B, and code 0x9 copies B into A. N and Z are taken from the copied byte, and V is cleared.
- R7: Code 0xA writes all eight bits of the flag register from A. Code 0xB copies the flag register into A and leaves the flag register unchanged.
- R8: Code 0xC swaps D with X, and code 0xD swaps D with Y. The swap happens in one cycle, and the flag register does not change.
- R9: A cycle with `cmd_valid` low, or with code 0xE or 0xF, changes no register and leaves `st_valid` low.
- R10: C and flag bits 7:4 keep their value through every command except the clears (C only) and code 0xA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| cmd_operand | input | 16 | Load operand |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| ccr | output | 8 | Flag register |
| st_valid | output | 1 | Store data valid, one cycle |
| st_data | output | 16 | Store data |

## Verification
The bench builds the unit with its default byte width of 8, so the word width is 16. This places the sign bits at positions 7 and 15, and it lets directed operands such as 0x80, 0x8000 and 0x0000 hit each sign and zero boundary. With a 4-bit code, all sixteen codes are reachable, including the two unused ones. A random run of several hundred commands then mixes stores, swaps and flag-register writes against the behavioural model.

// File: rtl/dmu_pkg.sv
package dmu_pkg;

  typedef enum logic [3:0] {
    OP_ZA   = 4'h0, OP_ZB   = 4'h1, OP_LA   = 4'h2, OP_LB   = 4'h3,
    OP_LW   = 4'h4, OP_SA   = 4'h5, OP_SB   = 4'h6, OP_SW   = 4'h7,
    OP_MAB  = 4'h8, OP_MBA  = 4'h9, OP_MAF  = 4'hA, OP_MFA  = 4'hB,
    OP_SWX  = 4'hC, OP_SWY  = 4'hD, OP_RES0 = 4'hE, OP_RES1 = 4'hF
  } dmu_op_e;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;

  typedef enum logic [2:0] {
    A_KEEP, A_ZERO, A_OPLO, A_OPHI, A_FRB, A_FRF, A_XHI, A_YHI
  } a_src_e;

  typedef enum logic [2:0] {
    B_KEEP, B_ZERO, B_OPLO, B_FRA, B_XLO, B_YLO
  } b_src_e;

  typedef enum logic [2:0] {
    F_KEEP, F_CLR, F_NZ8, F_NZ16, F_FRA
  } flg_e;

  typedef enum logic [1:0] {BY_OPLO, BY_A, BY_B} byte_sel_e;
  typedef enum logic       {W_OP, W_D}         word_sel_e;
  typedef enum logic [1:0] {S_A, S_B, S_D}     st_sel_e;

  typedef struct packed {
    a_src_e    a_src;
    b_src_e    b_src;
    logic      x_we;
    logic      y_we;
    flg_e      flg;
    byte_sel_e byte_sel;
    word_sel_e word_sel;
    logic      st_en;
    st_sel_e   st_sel;
  } dmu_ctl_t;

endpackage

// File: rtl/dmu_decode.sv
module dmu_decode
  import dmu_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] op,
  output dmu_ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    if (valid) begin
      case (dmu_op_e'(op))
        OP_ZA: begin ctl.a_src = A_ZERO; ctl.flg = F_CLR; end
        OP_ZB: begin ctl.b_src = B_ZERO; ctl.flg = F_CLR; end
        OP_LA: begin
          ctl.a_src = A_OPLO; ctl.byte_sel = BY_OPLO; ctl.flg = F_NZ8;
        end
        OP_LB: begin
          ctl.b_src = B_OPLO; ctl.byte_sel = BY_OPLO; ctl.flg = F_NZ8;
        end
        OP_LW: begin
          ctl.a_src = A_OPHI; ctl.b_src = B_OPLO;
          ctl.word_sel = W_OP; ctl.flg = F_NZ16;
        end
        OP_SA: begin
          ctl.st_en = 1'b1; ctl.st_sel = S_A;
          ctl.byte_sel = BY_A; ctl.flg = F_NZ8;
        end
        OP_SB: begin
          ctl.st_en = 1'b1; ctl.st_sel = S_B;
          ctl.byte_sel = BY_B; ctl.flg = F_NZ8;
        end
        OP_SW: begin
          ctl.st_en = 1'b1; ctl.st_sel = S_D;
          ctl.word_sel = W_D; ctl.flg = F_NZ16;
        end
        OP_MAB: begin
          ctl.b_src = B_FRA; ctl.byte_sel = BY_A; ctl.flg = F_NZ8;
        end
        OP_MBA: begin
          ctl.a_src = A_FRB; ctl.byte_sel = BY_B; ctl.flg = F_NZ8;
        end
        OP_MAF: ctl.flg = F_FRA;
        OP_MFA: ctl.a_src = A_FRF;
        OP_SWX: begin
          ctl.a_src = A_XHI; ctl.b_src = B_XLO; ctl.x_we = 1'b1;
        end
        OP_SWY: begin
          ctl.a_src = A_YHI; ctl.b_src = B_YLO; ctl.y_we = 1'b1;
        end
        default: ctl = '0;
      endcase
    end
  end

endmodule

// File: rtl/dmu_nz.sv
module dmu_nz #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic         zero
);

  assign neg  = val[W-1];
  assign zero = (val == '0);

endmodule

// File: rtl/dmu_store_port.sv
module dmu_store_port
  import dmu_pkg::*;
#(
  parameter int ACC_W = 8,
  localparam int WORD_W = 2 * ACC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_en,
  input  st_sel_e           st_sel,
  input  logic [ACC_W-1:0]  acc_a,
  input  logic [ACC_W-1:0]  acc_b,
  output logic              st_valid,
  output logic [WORD_W-1:0] st_data
);

  logic [WORD_W-1:0] data_nxt;

  always_comb begin
    case (st_sel)
      S_A:     data_nxt = {{ACC_W{1'b0}}, acc_a};
      S_B:     data_nxt = {{ACC_W{1'b0}}, acc_b};
      S_D:     data_nxt = {acc_a, acc_b};
      default: data_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_data  <= '0;
    end else begin
      st_valid <= st_en;
      if (st_en) st_data <= data_nxt;
    end
  end

endmodule

// File: rtl/dmu_core.sv
module dmu_core
  import dmu_pkg::*;
#(
  parameter int ACC_W = 8,
  localparam int WORD_W = 2 * ACC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_operand,
  output logic [ACC_W-1:0]  acc_a,
  output logic [ACC_W-1:0]  acc_b,
  output logic [WORD_W-1:0] idx_x,
  output logic [WORD_W-1:0] idx_y,
  output logic [ACC_W-1:0]  ccr,
  output logic              st_valid,
  output logic [WORD_W-1:0] st_data
);

  dmu_ctl_t          ctl;
  logic [ACC_W-1:0]  a_nxt, b_nxt, ccr_nxt, byte_val;
  logic [WORD_W-1:0] word_val;
  logic              byte_n, byte_z, word_n, word_z;

  dmu_decode u_dec (
    .valid (cmd_valid),
    .op    (cmd_op),
    .ctl   (ctl)
  );

  always_comb begin
    case (ctl.byte_sel)
      BY_A:    byte_val = acc_a;
      BY_B:    byte_val = acc_b;
      default: byte_val = cmd_operand[ACC_W-1:0];
    endcase
    word_val = (ctl.word_sel == W_D) ? {acc_a, acc_b} : cmd_operand;
  end

  dmu_nz #(.W(ACC_W)) u_nz_byte (
    .val (byte_val), .neg (byte_n), .zero (byte_z)
  );

  dmu_nz #(.W(WORD_W)) u_nz_word (
    .val (word_val), .neg (word_n), .zero (word_z)
  );

  always_comb begin
    case (ctl.a_src)
      A_ZERO:  a_nxt = '0;
      A_OPLO:  a_nxt = cmd_operand[ACC_W-1:0];
      A_OPHI:  a_nxt = cmd_operand[WORD_W-1:ACC_W];
      A_FRB:   a_nxt = acc_b;
      A_FRF:   a_nxt = ccr;
      A_XHI:   a_nxt = idx_x[WORD_W-1:ACC_W];
      A_YHI:   a_nxt = idx_y[WORD_W-1:ACC_W];
      default: a_nxt = acc_a;
    endcase
  end

  always_comb begin
    case (ctl.b_src)
      B_ZERO:  b_nxt = '0;
      B_OPLO:  b_nxt = cmd_operand[ACC_W-1:0];
      B_FRA:   b_nxt = acc_a;
      B_XLO:   b_nxt = idx_x[ACC_W-1:0];
      B_YLO:   b_nxt = idx_y[ACC_W-1:0];
      default: b_nxt = acc_b;
    endcase
  end

  always_comb begin
    ccr_nxt = ccr;
    case (ctl.flg)
      F_CLR: begin
        ccr_nxt[FLG_N] = 1'b0;
        ccr_nxt[FLG_Z] = 1'b1;
        ccr_nxt[FLG_V] = 1'b0;
        ccr_nxt[FLG_C] = 1'b0;
      end
      F_NZ8: begin
        ccr_nxt[FLG_N] = byte_n;
        ccr_nxt[FLG_Z] = byte_z;
        ccr_nxt[FLG_V] = 1'b0;
      end
      F_NZ16: begin
        ccr_nxt[FLG_N] = word_n;
        ccr_nxt[FLG_Z] = word_z;
        ccr_nxt[FLG_V] = 1'b0;
      end
      F_FRA:   ccr_nxt = acc_a;
      default: ccr_nxt = ccr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a <= '0;
      acc_b <= '0;
      idx_x <= '0;
      idx_y <= '0;
      ccr   <= '0;
    end else begin
      acc_a <= a_nxt;
      acc_b <= b_nxt;
      ccr   <= ccr_nxt;
      if (ctl.x_we) idx_x <= {acc_a, acc_b};
      if (ctl.y_we) idx_y <= {acc_a, acc_b};
    end
  end

  dmu_store_port #(.ACC_W(ACC_W)) u_st (
    .clk      (clk),
    .rst      (rst),
    .st_en    (ctl.st_en),
    .st_sel   (ctl.st_sel),
    .acc_a    (acc_a),
    .acc_b    (acc_b),
    .st_valid (st_valid),
    .st_data  (st_data)
  );

  // R2
  clr_a_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ZA) |=>
      (acc_a == '0 && ccr[FLG_Z] && !ccr[FLG_N] && !ccr[FLG_V] && !ccr[FLG_C]));

  // R8
  swap_x_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_SWX) |=>
      (idx_x == $past({acc_a, acc_b}) && {acc_a, acc_b} == $past(idx_x) && $stable(ccr)));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid) |=>
      ($stable(acc_a) && $stable(acc_b) && $stable(idx_x) && $stable(idx_y)
       && $stable(ccr) && !st_valid));

  // R5
  store_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == OP_SA || cmd_op == OP_SB || cmd_op == OP_SW)) |=>
      (st_valid && $stable(acc_a) && $stable(acc_b) && $stable(idx_x) && $stable(idx_y)));

  // R10
  carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op != OP_ZA && cmd_op != OP_ZB && cmd_op != OP_MAF) |=>
      ($stable(ccr[FLG_C]) && $stable(ccr[ACC_W-1:4])));

endmodule

// File: tb/test_dmu_core.sv
module test_dmu_core;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [15:0] cmd_operand;
  logic [7:0]  acc_a, acc_b, ccr;
  logic [15:0] idx_x, idx_y, st_data;
  logic        st_valid;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0]  m_a, m_b, m_f;
  logic [15:0] m_x, m_y, m_sd;
  logic        m_sv;

  always #10 clk = ~clk;

  dmu_core i_dmu_core (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .cmd_operand (cmd_operand), .acc_a (acc_a), .acc_b (acc_b),
    .idx_x (idx_x), .idx_y (idx_y), .ccr (ccr),
    .st_valid (st_valid), .st_data (st_data)
  );

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk(req, "acc_a", {8'h0, acc_a}, {8'h0, m_a});
    chk(req, "acc_b", {8'h0, acc_b}, {8'h0, m_b});
    chk(req, "idx_x", idx_x, m_x);
    chk(req, "idx_y", idx_y, m_y);
    chk(req, "ccr", {8'h0, ccr}, {8'h0, m_f});
    chk(req, "st_valid", {15'h0, st_valid}, {15'h0, m_sv});
    chk(req, "st_data", st_data, m_sd);
  endtask

  function automatic void nz8(logic [7:0] v);
    m_f[3] = v[7]; m_f[2] = (v == 8'h00); m_f[1] = 1'b0;
  endfunction

  function automatic void nz16(logic [15:0] v);
    m_f[3] = v[15]; m_f[2] = (v == 16'h0000); m_f[1] = 1'b0;
  endfunction

  function automatic string req_of(logic v, logic [3:0] op);
    if (!v) return "R9";
    case (op)
      4'h0, 4'h1: return "R2";
      4'h2, 4'h3: return "R3";
      4'h4: return "R4";
      4'h5, 4'h6, 4'h7: return "R5";
      4'h8, 4'h9: return "R6";
      4'hA, 4'hB: return "R7";
      4'hC, 4'hD: return "R8";
      default: return "R9";
    endcase
  endfunction

  // one command: drive after negedge, model it, compare at the next negedge
  task automatic step(logic v, logic [3:0] op, logic [15:0] opnd, string req);
    logic [15:0] t;
    cmd_valid = v; cmd_op = op; cmd_operand = opnd;
    m_sv = 1'b0;
    if (v) begin
      case (op)
        4'h0: begin m_a = 8'h00; m_f[3:0] = 4'b0100; end
        4'h1: begin m_b = 8'h00; m_f[3:0] = 4'b0100; end
        4'h2: begin m_a = opnd[7:0]; nz8(m_a); end
        4'h3: begin m_b = opnd[7:0]; nz8(m_b); end
        4'h4: begin m_a = opnd[15:8]; m_b = opnd[7:0]; nz16(opnd); end
        4'h5: begin m_sv = 1'b1; m_sd = {8'h00, m_a}; nz8(m_a); end
        4'h6: begin m_sv = 1'b1; m_sd = {8'h00, m_b}; nz8(m_b); end
        4'h7: begin m_sv = 1'b1; m_sd = {m_a, m_b}; nz16({m_a, m_b}); end
        4'h8: begin m_b = m_a; nz8(m_b); end
        4'h9: begin m_a = m_b; nz8(m_a); end
        4'hA: m_f = m_a;
        4'hB: m_a = m_f;
        4'hC: begin t = {m_a, m_b}; {m_a, m_b} = m_x; m_x = t; end
        4'hD: begin t = {m_a, m_b}; {m_a, m_b} = m_y; m_y = t; end
        default: ;
      endcase
    end
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b1; cmd_op = 4'h2; cmd_operand = 16'hFFFF;
    m_a = 0; m_b = 0; m_x = 0; m_y = 0; m_f = 0; m_sd = 0; m_sv = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst = 1'b0;
    step(1'b0, 4'h2, 16'h00AA, "R9");
    step(1'b1, 4'h2, 16'h1280, "R3");   // negative byte
    step(1'b1, 4'h3, 16'hFF00, "R3");   // zero byte
    step(1'b1, 4'h4, 16'h8000, "R4");   // word sign at bit 15
    step(1'b1, 4'h4, 16'h0000, "R4");   // zero word
    step(1'b1, 4'h4, 16'h0180, "R4");   // low byte sign bit does not make word negative
    step(1'b1, 4'h2, 16'h00FF, "R3");
    step(1'b1, 4'hA, 16'h0000, "R7");   // flags := 0xFF
    step(1'b1, 4'h2, 16'h0001, "R10");  // C and upper bits must survive
    step(1'b1, 4'h5, 16'h0000, "R5");
    step(1'b1, 4'h6, 16'h0000, "R5");
    step(1'b1, 4'h7, 16'h0000, "R5");
    step(1'b1, 4'h8, 16'h0000, "R6");
    step(1'b1, 4'h3, 16'h0090, "R3");
    step(1'b1, 4'h9, 16'h0000, "R6");
    step(1'b1, 4'hB, 16'h0000, "R7");
    step(1'b1, 4'h4, 16'hBEEF, "R4");
    step(1'b1, 4'hC, 16'h0000, "R8");
    step(1'b1, 4'h4, 16'h1357, "R4");
    step(1'b1, 4'hD, 16'h0000, "R8");
    step(1'b1, 4'hC, 16'h0000, "R8");
    step(1'b1, 4'hE, 16'h00FF, "R9");
    step(1'b1, 4'hF, 16'h00FF, "R9");
    step(1'b1, 4'h0, 16'h0000, "R2");
    step(1'b1, 4'h1, 16'h0000, "R2");
    for (int i = 0; i < 600; i++) begin
      logic        v;
      logic [3:0]  op;
      logic [15:0] d;
      v  = ($urandom % 4) != 0;
      op = 4'($urandom % 16);
      d  = 16'($urandom);
      step(v, op, d, req_of(v, op));
    end
    cmd_valid = 1'b1; cmd_op = 4'h4; cmd_operand = 16'h5555;
    rst = 1'b1;
    m_a = 0; m_b = 0; m_x = 0; m_y = 0; m_f = 0; m_sd = 0; m_sv = 0;
    @(negedge clk);
    compare_all("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule